// File: doc/BRIEF.md
# Dual-mode SPI serial clock divider

This block derives the SPI serial clock from the module clock. A 32-bit clock-control word selects between two divide schemes. The linear scheme divides by 2*(N+1), which gives even ratios from 2 to 512. The exponential scheme divides by 2^(M+1). The duty cycle is always 50%, because each half-period is a whole number of module clocks: N+1 in linear mode and 2^M in exponential mode.

Alongside the clock, the block drives two one-cycle strobes for a neighbouring shift engine. One marks each edge that leaves the idle level and the other marks each edge that returns to it. A run input starts and stops the toggling. While stopped, the serial clock rests at the idle polarity chosen by the polarity input.

The control word is sampled into an active copy. A new value is taken while the block is idle, or at the end of a half-period while it runs. A rewrite during a half-period therefore never shortens or stretches that half-period.

Top module: `spi_clk_div`

## Requirements
- R1: While rst_ni is low, sck_o, lead_o and trail_o are all 0.
- R2: Linear mode has bit 12 of cfg_i at 1 and N in bits 7:0. Every half-period of sck_o is then N+1 module clocks, so the full period is 2*(N+1). Bits 11:8 have no effect in this mode.
- R3: Exponential mode has bit 12 of cfg_i at 0 and M in bits 11:8. Every half-period of sck_o is then 2^M module clocks. Bits 7:0 have no effect in this mode.
- R4: Whenever run_i is sampled low at a clock edge, sck_o takes the value of cpol_i at that edge. Neither strobe fires, and the half-period count restarts from zero.
- R5: While running, a change to cfg_i takes effect only from the next half-period boundary. While idle, a change takes effect at the next clock edge.
- R6: lead_o is high for exactly the one clock in which sck_o has just left the cpol_i level. trail_o is high for exactly the one clock in which sck_o has just returned to that level. The two never fire together, and neither fires without an sck_o transition.
- R7: After run_i rises, the first sck_o transition happens at the H-th clock edge that samples run_i high, where H is the half-period length.
- R8: Bits 31:13 of cfg_i have no effect on sck_o or on the strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Clock-control word: N in 7:0, M in 11:8, mode select in 12 |
| run_i | input | 1 | High to toggle sck_o, low to park it |
| cpol_i | input | 1 | Idle level of sck_o |
| sck_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-clock strobe on each edge that leaves the idle level |
| trail_o | output | 1 | One-clock strobe on each edge that returns to the idle level |

## Verification
The bench sweeps N from 0 to 15 and also N=255, and sweeps M from 0 to 10, under both polarities. It times the first three transitions of each run. An off-by-one in the terminal count, or a mix-up between 2^M and 2^(M+1), shows up as a wrong interval. N=0 is the narrowest case: a design that cannot toggle on every clock stalls or doubles the period there. The bench also rewrites the control word in the middle of a half-period. A design that applies the new value at once produces a shortened half-period. Finally, the bench loads words with noise in the unused fields and upper bits. A decoder that reads the wrong bits then produces a wrong interval.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;
  localparam int unsigned LIN_W   = 8;
  localparam int unsigned EXP_W   = 4;
  localparam int unsigned SEL_POS = LIN_W + EXP_W;
  // terminal count is N (linear) or 2^M-1 (exponential)
  localparam int unsigned EXP_MAX = (2 ** EXP_W) - 1;
  localparam int unsigned CNT_W   = (EXP_MAX > LIN_W) ? EXP_MAX : LIN_W;

  typedef struct packed {
    logic             sel;
    logic [EXP_W-1:0] m;
    logic [LIN_W-1:0] n;
  } div_cfg_t;
endpackage

// File: rtl/spi_clk_div_cfg.sv
module spi_clk_div_cfg
  import spi_clk_div_pkg::*;
#(
  parameter int unsigned CFG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             run_i,
  input  logic             bnd_i,
  output div_cfg_t         act_o,
  output logic [CNT_W-1:0] term_o
);
  div_cfg_t act_q;
  logic [CNT_W-1:0] exp_mask;
  logic cfg_unused_w;

  assign cfg_unused_w = ^cfg_i[CFG_W-1:SEL_POS+1];

  // load while idle, or at a half-period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               act_q <= '0;
    else if (!run_i || bnd_i)  act_q <= div_cfg_t'(cfg_i[SEL_POS:0]);
  end

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign exp_mask[i] = (i < int'(act_q.m));
  end

  assign term_o = act_q.sel ? CNT_W'(act_q.n) : exp_mask;
  assign act_o  = act_q;
endmodule

// File: rtl/spi_clk_div_cnt.sv
module spi_clk_div_cnt
  import spi_clk_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             bnd_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign bnd_o = run_i && (cnt_q == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || bnd_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/spi_clk_div_edge.sv
module spi_clk_div_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic cpol_i,
  input  logic bnd_i,
  output logic sck_o,
  output logic lead_o,
  output logic trail_o
);
  logic sck_q, lead_q, trail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!run_i) begin
      sck_q   <= cpol_i;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (bnd_i) begin
      sck_q   <= ~sck_q;
      lead_q  <= (sck_q == cpol_i);
      trail_q <= (sck_q != cpol_i);
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end
  end

  assign sck_o   = sck_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_clk_div_pkg::*;
#(
  parameter int unsigned CFG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             run_i,
  input  logic             cpol_i,
  output logic             sck_o,
  output logic             lead_o,
  output logic             trail_o
);
  div_cfg_t         act_w;
  logic [CNT_W-1:0] term_w;
  logic [CNT_W-1:0] cnt_w;
  logic             bnd_w;

  spi_clk_div_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_i),
    .run_i  (run_i),
    .bnd_i  (bnd_w),
    .act_o  (act_w),
    .term_o (term_w)
  );

  spi_clk_div_cnt u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .term_i (term_w),
    .bnd_o  (bnd_w),
    .cnt_o  (cnt_w)
  );

  spi_clk_div_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .cpol_i  (cpol_i),
    .bnd_i   (bnd_w),
    .sck_o   (sck_o),
    .lead_o  (lead_o),
    .trail_o (trail_o)
  );
endmodule

// File: rtl/spi_clk_div_chk.sv
module spi_clk_div_chk
  import spi_clk_div_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             cpol_i,
  input logic             sck_o,
  input logic             lead_o,
  input logic             trail_o,
  input logic             bnd_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] term_i,
  input logic [SEL_POS:0] act_i
);
  p_idle_park_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sck_o == $past(cpol_i)));

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!lead_o && !trail_o && cnt_i == '0));

  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  p_strobe_on_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_o || trail_o) |-> (sck_o != $past(sck_o)));

  p_edge_strobed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && sck_o != $past(sck_o)) |-> (lead_o || trail_o));

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= term_i);

  p_cfg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && !$past(bnd_i)) |-> $stable(act_i));
endmodule

bind spi_clk_div spi_clk_div_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .cpol_i  (cpol_i),
  .sck_o   (sck_o),
  .lead_o  (lead_o),
  .trail_o (trail_o),
  .bnd_i   (bnd_w),
  .cnt_i   (cnt_w),
  .term_i  (term_w),
  .act_i   (act_w)
);

// File: tb/spi_clk_div_tb_top.sv
module spi_clk_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic        run = 1'b0;
  logic        cpol = 1'b0;
  logic        sck, lead, trail;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;

  always #4 clk = ~clk;

  spi_clk_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .run_i(run), .cpol_i(cpol),
    .sck_o(sck), .lead_o(lead), .trail_o(trail)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_toggle(output int n);
    logic s0;
    s0 = sck;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sck == s0 && n < 70000);
  endtask

  // idle load, run, time three transitions, park
  task automatic measure(input logic [31:0] c, input logic pol, input int h,
                         input string req);
    int n;
    @(negedge clk);
    run = 1'b0; cfg = c; cpol = pol;
    @(negedge clk);
    @(negedge clk);
    chk(sck == pol, "R4", "idle sck", sck, pol);
    chk(!lead && !trail, "R4", "idle strobes", {lead, trail}, 0);
    run = 1'b1;
    wait_toggle(n);
    chk(n == h, "R7", "first edge delay", n, h);
    chk(lead && !trail, "R6", "lead on first edge", {lead, trail}, 2);
    wait_toggle(n);
    chk(n == h, req, "half period", n, h);
    chk(trail && !lead, "R6", "trail on return edge", {lead, trail}, 1);
    wait_toggle(n);
    chk(n == h, req, "half period", n, h);
    chk(lead && !trail, "R6", "lead again", {lead, trail}, 2);
    @(negedge clk);
    chk(!lead, "R6", "lead width", lead, 0);
    run = 1'b0;
    @(negedge clk);
    chk(sck == pol, "R4", "park level", sck, pol);
    chk(!lead && !trail, "R4", "park strobes", {lead, trail}, 0);
  endtask

  initial begin
    int n;
    #1;
    chk(sck == 1'b0 && !lead && !trail, "R1", "reset outputs",
        {sck, lead, trail}, 0);
    repeat (3) @(negedge clk);
    chk(sck == 1'b0 && !lead && !trail, "R1", "reset held",
        {sck, lead, trail}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++)
      measure(32'h1000 | i, i[0], i + 1, "R2");
    measure(32'h10FF, 1'b0, 256, "R2");
    measure(32'h1000 | (32'hF << 8) | 1, 1'b1, 2, "R2");

    for (int m = 0; m <= 10; m++)
      measure(m << 8, m[0], 1 << m, "R3");
    measure((3 << 8) | 32'hFF, 1'b0, 8, "R3");

    measure(32'hFFFF_E000 | 32'h1002, 1'b1, 3, "R8");
    measure(32'hA5A5_0000 | (2 << 8), 1'b0, 4, "R8");

    // R5: rewrite mid half-period while running
    @(negedge clk);
    run = 1'b0; cfg = 32'h1003; cpol = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    wait_toggle(n);
    chk(n == 4, "R5", "initial half", n, 4);
    @(negedge clk);
    cfg = 32'h1001;
    n = 1;
    while (sck == 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == 4, "R5", "half in flight keeps old length", n, 4);
    wait_toggle(n);
    chk(n == 2, "R5", "new length from boundary", n, 2);

    // R5: idle change applies at next edge
    @(negedge clk);
    run = 1'b0; cfg = 32'h1003;
    @(negedge clk);
    cfg = 32'h1005;
    @(negedge clk);
    run = 1'b1;
    wait_toggle(n);
    chk(n == 6, "R5", "idle load immediate", n, 6);
    run = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule